// File: doc/BRIEF.md
# Two-Bit Hysteresis Branch Predictor with Tagged Target Buffer

This block predicts, for each instruction fetch address, whether a branch there will be taken and where it will go. It keeps a direct-mapped table with one direction state per entry and a tagged target buffer beside it. A fetch unit presents its program counter and, in the same cycle, gets a combinational prediction: taken, target hit, and the predicted fetch address. When a branch resolves later in the pipeline, the resolved address, its outcome and its actual target are sent back as an update. The update advances that entry's direction state and, for a taken branch, records the target.

The direction state uses four codes arranged for hysteresis: two codes predict not taken (strong 00, weak 01) and two predict taken (strong 11, weak 10). A single surprise only weakens a strong state, so the predicted direction flips only after two mispredictions in a row. A parameter swaps the direction table for a one-bit last-outcome table, so the two schemes can be compared on the same address stream.

Top module: `bp_hyst_btb`

## Requirements
- R1: Direction codes: 2'b00 and 2'b01 predict not taken, 2'b11 and 2'b10 predict taken; the predicted direction is the upper bit of the entry's code.
- R2: On a taken update, 00 goes to 01, 01 goes to 11, and 11 stays 11.
- R3: On a not-taken update, 11 goes to 10, 10 goes to 00, and 00 stays 00.
- R4: A weak state that sees the outcome it predicts returns to its strong state: 01 with not taken goes to 00, 10 with taken goes to 11.
- R5: Starting from a strong state, the predicted direction changes only after two consecutive opposite outcomes; one opposite outcome leaves the prediction unchanged.
- R6: With ONE_BIT=1 each entry holds only the last outcome (0 predicts not taken, 1 predicts taken) and the next lookup predicts exactly that outcome.
- R7: After reset every entry is in state 00 and every target is invalid, so every lookup returns lk_hit=0, lk_taken=0 and lk_target=0.
- R8: Entry index is pc[OFFSET_W +: IDX_W] (bits 5:2 by default) and the tag is all bits above it; addresses with the same index share one direction state, but a target hit needs a valid entry whose tag equals the lookup tag.
- R9: A taken update writes the target, tag and valid bit of its entry; a not-taken update leaves the target buffer untouched.
- R10: Lookup is combinational from lk_pc; an update takes effect at the clock edge, so a lookup of the same entry in the update's cycle sees the old contents.
- R11: lk_taken is asserted only when the direction predicts taken and the target hits; otherwise it falls back to not taken. lk_target is the stored target on a hit and 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | ADDR_W | Fetch address to predict |
| lk_taken | output | 1 | Predict taken (with a target hit) |
| lk_hit | output | 1 | Target buffer holds a valid entry for lk_pc |
| lk_target | output | ADDR_W | Predicted fetch address on a hit, else 0 |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
A two-bit instance and a one-bit instance receive identical stimulus, so an alternating outcome stream shows the one-bit table flipping every time while the hysteresis table holds its direction after a single surprise. Directed runs walk an entry through every code and every edge of the state graph, including the weak-state returns, and look up an address sharing an index with a trained branch to separate shared direction from tag-checked target hits and the not-taken fallback. Lookups issued in the same cycle as an update to the same entry distinguish a registered write from a write-through path, and a long stream of random updates over a small address pool mixes aliasing, target replacement and not-taken updates that must leave targets alone.

// File: rtl/bp_pkg.sv
package bp_pkg;

   // Direction codes; the upper bit is the predicted direction.
   typedef enum logic [1:0] {
      ST_STRONG_NT = 2'b00,
      ST_WEAK_NT   = 2'b01,
      ST_STRONG_TK = 2'b11,
      ST_WEAK_TK   = 2'b10
   } hyst_st_e;

   function automatic hyst_st_e hyst_next(input hyst_st_e cur, input logic taken);
      hyst_st_e nxt;
      unique case (cur)
         ST_STRONG_NT: nxt = taken ? ST_WEAK_NT   : ST_STRONG_NT;
         ST_WEAK_NT:   nxt = taken ? ST_STRONG_TK : ST_STRONG_NT;
         ST_STRONG_TK: nxt = taken ? ST_STRONG_TK : ST_WEAK_TK;
         ST_WEAK_TK:   nxt = taken ? ST_STRONG_TK : ST_STRONG_NT;
         default:      nxt = ST_STRONG_NT;
      endcase
      return nxt;
   endfunction

   function automatic logic hyst_dir(input hyst_st_e cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bp_index_split.sv
module bp_index_split #(
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 2,
   parameter int IDX_W    = 4,
   parameter int TAG_W    = ADDR_W - OFFSET_W - IDX_W
) (
   input  logic [ADDR_W-1:0] pc,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);

   assign idx = pc[OFFSET_W +: IDX_W];
   assign tag = pc[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table
   import bp_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter bit ONE_BIT = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IDX_W-1:0]       rd_idx,
   output logic                   rd_taken,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic                   wr_taken,
   output logic [2*ENTRIES-1:0]   st_flat
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic hit_wr;
      assign hit_wr = wr_en && (wr_idx == IDX_W'(e));

      if (ONE_BIT) begin : g_one
         logic last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      last_q <= 1'b0;
            else if (hit_wr) last_q <= wr_taken;
         end
         assign st_flat[2*e +: 2] = {last_q, 1'b0};
      end else begin : g_two
         hyst_st_e st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      st_q <= ST_STRONG_NT;
            else if (hit_wr) st_q <= hyst_next(st_q, wr_taken);
         end
         assign st_flat[2*e +: 2] = st_q;
      end
   end

   // Upper bit of each two-bit slot is the predicted direction in both variants.
   assign rd_taken = st_flat[{rd_idx, 1'b1}];

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int TAG_W   = 26,
   parameter int ADDR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_hit,
   output logic [ADDR_W-1:0] rd_target,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [ADDR_W-1:0] wr_target
);

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [ADDR_W-1:0]  tgt_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i] <= '0;
            tgt_q[i] <= '0;
         end
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_target;
      end
   end

   assign rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_target = rd_hit ? tgt_q[rd_idx] : '0;

endmodule

// File: rtl/bp_hyst_btb.sv
module bp_hyst_btb #(
   parameter int ADDR_W   = 32,
   parameter int ENTRIES  = 16,
   parameter int OFFSET_W = 2,
   parameter bit ONE_BIT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   output logic              lk_taken,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_target,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_pc,
   input  logic              up_taken,
   input  logic [ADDR_W-1:0] up_target
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int TAG_W = ADDR_W - OFFSET_W - IDX_W;

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("bp_hyst_btb: ENTRIES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("bp_hyst_btb: ADDR_W too small for ENTRIES and OFFSET_W");
   end

   logic [IDX_W-1:0]     lk_idx, up_idx;
   logic [TAG_W-1:0]     lk_tag, up_tag;
   logic                 dir_taken;
   logic                 tb_hit;
   logic [ADDR_W-1:0]    tb_target;
   logic [2*ENTRIES-1:0] dir_st_flat;

   bp_index_split #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
      u_split_lk (.pc(lk_pc), .idx(lk_idx), .tag(lk_tag));

   bp_index_split #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
      u_split_up (.pc(up_pc), .idx(up_idx), .tag(up_tag));

   bp_dir_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .ONE_BIT(ONE_BIT)) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_taken (dir_taken),
      .wr_en    (up_valid),
      .wr_idx   (up_idx),
      .wr_taken (up_taken),
      .st_flat  (dir_st_flat)
   );

   bp_target_buf #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_tbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (lk_idx),
      .rd_tag    (lk_tag),
      .rd_hit    (tb_hit),
      .rd_target (tb_target),
      .wr_en     (up_valid && up_taken),
      .wr_idx    (up_idx),
      .wr_tag    (up_tag),
      .wr_target (up_target)
   );

   assign lk_hit    = tb_hit;
   assign lk_target = tb_target;
   assign lk_taken  = dir_taken && tb_hit;

endmodule

// File: rtl/bp_hyst_btb_chk.sv
module bp_hyst_btb_chk #(
   parameter int ADDR_W   = 32,
   parameter int ENTRIES  = 16,
   parameter int OFFSET_W = 2,
   parameter bit ONE_BIT  = 1'b0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      lk_pc,
   input logic                   lk_taken,
   input logic                   lk_hit,
   input logic [ADDR_W-1:0]      lk_target,
   input logic                   up_valid,
   input logic [ADDR_W-1:0]      up_pc,
   input logic                   up_taken,
   input logic [ADDR_W-1:0]      up_target,
   input logic [2*ENTRIES-1:0]   st_flat
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [IDX_W-1:0]  u_idx;
   logic [1:0]        u_st;
   logic              p_v, p_t;
   logic [1:0]        p_st;
   logic [IDX_W-1:0]  p_idx;
   logic [ADDR_W-1:0] p_pc, p_tgt;
   logic [1:0]        n_st;

   assign u_idx = up_pc[OFFSET_W +: IDX_W];
   assign u_st  = st_flat[{u_idx, 1'b0} +: 2];
   assign n_st  = st_flat[{p_idx, 1'b0} +: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_v <= 1'b0; p_t <= 1'b0; p_st <= '0; p_idx <= '0; p_pc <= '0; p_tgt <= '0;
      end else begin
         p_v <= up_valid; p_t <= up_taken; p_st <= u_st; p_idx <= u_idx;
         p_pc <= up_pc; p_tgt <= up_target;
      end
   end

   // R5: one taken outcome from strong not-taken keeps predicting not taken
   assert_strong_nt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ONE_BIT && p_v && p_t && p_st == 2'b00) |-> (n_st == 2'b01));

   // R2: second taken outcome reaches strong taken
   assert_weak_nt_to_strong_tk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ONE_BIT && p_v && p_t && p_st == 2'b01) |-> (n_st == 2'b11));

   // R3: one not-taken outcome from strong taken goes to weak taken
   assert_strong_tk_weakens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ONE_BIT && p_v && !p_t && p_st == 2'b11) |-> (n_st == 2'b10));

   // R4: weak not-taken confirmed returns to strong not-taken
   assert_weak_nt_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ONE_BIT && p_v && !p_t && p_st == 2'b01) |-> (n_st == 2'b00));

   // R6: one-bit mode keeps the last outcome
   assert_one_bit_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ONE_BIT && p_v) |-> (n_st[1] == p_t));

   // R11: taken is never predicted without a target hit
   assert_taken_needs_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lk_taken |-> lk_hit);

   // R9: a taken update is visible as a hit with its target on the next cycle
   assert_target_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (p_v && p_t && lk_pc == p_pc) |-> (lk_hit && lk_target == p_tgt));

   // R11: a miss drives a zero target
   assert_miss_zero_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_target == '0));

endmodule

bind bp_hyst_btb bp_hyst_btb_chk #(
   .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .OFFSET_W(OFFSET_W), .ONE_BIT(ONE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hit(lk_hit),
   .lk_target(lk_target), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
   .up_target(up_target), .st_flat(dir_st_flat)
);

// File: tb/bp_hyst_btb_bench.sv
module bp_hyst_btb_bench;

   localparam int CLK_T = 10;
   localparam int AW    = 32;
   localparam int NE    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] lk_pc = '0;
   logic          up_valid = 1'b0;
   logic [AW-1:0] up_pc = '0;
   logic          up_taken = 1'b0;
   logic [AW-1:0] up_target = '0;

   logic          t2_taken, t2_hit, t1_taken, t1_hit;
   logic [AW-1:0] t2_target, t1_target;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_T/2) clk = ~clk;

   bp_hyst_btb #(.ADDR_W(AW), .ENTRIES(NE), .OFFSET_W(2), .ONE_BIT(1'b0)) u_bp_hyst_btb (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(t2_taken), .lk_hit(t2_hit),
      .lk_target(t2_target), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_target(up_target));

   bp_hyst_btb #(.ADDR_W(AW), .ENTRIES(NE), .OFFSET_W(2), .ONE_BIT(1'b1)) u_bp_hyst_btb_onebit (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(t1_taken), .lk_hit(t1_hit),
      .lk_target(t1_target), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_target(up_target));

   // Reference model: direction as (prediction, weak flag); one-bit as last outcome.
   bit      m_pred [NE];
   bit      m_weak [NE];
   bit      m_last [NE];
   bit      m_vld  [NE];
   int unsigned m_tag [NE];
   logic [AW-1:0] m_tgt [NE];

   function automatic int idx_of(input logic [AW-1:0] pc);
      return int'((pc >> 2) % NE);
   endfunction

   function automatic int unsigned tag_of(input logic [AW-1:0] pc);
      return int'(pc >> 6);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NE; i++) begin
         m_pred[i] = 0; m_weak[i] = 0; m_last[i] = 0; m_vld[i] = 0; m_tag[i] = 0; m_tgt[i] = '0;
      end
   endtask

   task automatic model_update(input logic [AW-1:0] pc, input bit tk, input logic [AW-1:0] tg);
      int i;
      i = idx_of(pc);
      if (tk == m_pred[i]) m_weak[i] = 0;
      else if (m_weak[i]) begin m_pred[i] = tk; m_weak[i] = 0; end
      else m_weak[i] = 1;
      m_last[i] = tk;
      if (tk) begin m_vld[i] = 1; m_tag[i] = tag_of(pc); m_tgt[i] = tg; end
   endtask

   task automatic cmp(input string req, input string what, input logic [AW-1:0] act,
                      input logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_out(input string req);
      int i; bit hit;
      i = idx_of(lk_pc);
      hit = m_vld[i] && (m_tag[i] == tag_of(lk_pc));
      cmp(req, "two-bit hit",    AW'(t2_hit),    AW'(hit));
      cmp(req, "two-bit taken",  AW'(t2_taken),  AW'(hit && m_pred[i]));
      cmp(req, "two-bit target", t2_target,      hit ? m_tgt[i] : '0);
      cmp(req, "one-bit hit",    AW'(t1_hit),    AW'(hit));
      cmp(req, "one-bit taken",  AW'(t1_taken),  AW'(hit && m_last[i]));
      cmp(req, "one-bit target", t1_target,      hit ? m_tgt[i] : '0);
   endtask

   // One cycle: drive at the falling edge, check the combinational lookup,
   // then apply the update to the model at the rising edge.
   task automatic step(input logic [AW-1:0] lpc, input bit uv, input logic [AW-1:0] upc,
                       input bit ut, input logic [AW-1:0] utg, input string req);
      @(negedge clk);
      lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg;
      #1;
      check_out(req);
      @(posedge clk);
      if (uv) model_update(upc, ut, utg);
   endtask

   localparam logic [AW-1:0] PA = 32'h0000_1010;  // index 4
   localparam logic [AW-1:0] PB = 32'h0000_2010;  // index 4, other tag
   localparam logic [AW-1:0] PC = 32'h0000_1024;  // index 9
   localparam logic [AW-1:0] TA = 32'h0000_8000;
   localparam logic [AW-1:0] TB = 32'h0000_9000;

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      lk_pc = PA; #1; check_out("R7");
      rst_n = 1'b1;
      step(PC, 0, '0, 0, '0, "R7");
      step(PB, 0, '0, 0, '0, "R7");
      // R10: same-cycle lookup sees old contents
      step(PA, 1, PA, 1, TA, "R10");          // 00 -> 01
      step(PA, 1, PA, 1, TA, "R2");           // hit, still not taken; 01 -> 11
      step(PA, 1, PA, 1, TA, "R2");           // taken; 11 stays
      step(PA, 1, PA, 0, '0, "R1");           // 11 -> 10
      step(PA, 0, '0, 0, '0, "R5");           // weak taken still predicts taken
      step(PA, 1, PA, 1, TA, "R4");           // 10 -> 11
      step(PA, 1, PA, 0, '0, "R3");           // 11 -> 10
      step(PA, 1, PA, 0, '0, "R5");           // 10 -> 00
      step(PA, 1, PA, 0, '0, "R3");           // 00 stays, target kept (R9)
      step(PA, 1, PA, 1, TB, "R9");           // 00 -> 01, new target
      step(PA, 1, PA, 0, '0, "R4");           // 01 -> 00
      step(PA, 1, PA, 1, TA, "R6");           // alternating: one-bit flips every time
      step(PA, 1, PA, 0, '0, "R6");
      step(PA, 1, PA, 1, TA, "R6");
      step(PA, 1, PA, 1, TA, "R6");           // two-bit now strong taken
      step(PB, 0, '0, 0, '0, "R8");           // same index, other tag: miss
      step(PB, 1, PB, 0, '0, "R9");           // not-taken update leaves A's target
      step(PA, 1, PB, 1, TB, "R8");           // B takes over the entry
      step(PA, 0, '0, 0, '0, "R11");          // A direction taken but target misses
      step(PB, 1, PC, 1, TA, "R8");
      step(PC, 0, '0, 0, '0, "R8");
      for (int k = 0; k < 400; k++) begin
         logic [AW-1:0] lp, upc;
         lp  = {22'h0, 4'(1 + $urandom_range(0, 1)), 4'($urandom_range(0, 3)), 2'b00};
         upc = {22'h0, 4'(1 + $urandom_range(0, 1)), 4'($urandom_range(0, 3)), 2'b00};
         step(lp, bit'($urandom_range(0, 3) != 0), upc, bit'($urandom_range(0, 1)),
              AW'($urandom) & ~32'h3, "R1");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_T * 200000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule